// File: doc/BRIEF.md
# Sticky Flash Status Register

This block keeps the 8-bit status word of a flash device's program/erase engine and shows it to a host over a data bus that is either 8 or 16 bits wide. The engine's write state machine marks activity and faults with per-bit set and clear masks. A one-cycle clear strobe from the command sequencer wipes the fault bits. The host reads the word by pulling chip-enable and output-enable low. The word is frozen when the second of the two goes low, so a bit that changes during a read cannot corrupt the value on the bus.

The fault bits are sticky. The state machine can raise them but has no way to drop them, so a failure stays visible until the host acknowledges it. The bit meanings are: bit 7 ready (1 = idle), bit 6 erase suspended, bit 5 erase fault, bit 4 program fault, bit 3 supply-voltage fault. Bits 2..0 are reserved and always read as 0.

The chip-enable and output-enable pins are asynchronous. They pass through a synchronizer of `SYNC_STAGES` flops before the read logic uses them. No data stream crosses the block: every pin is a plain control or status level, so no valid/ready handshake or back-pressure applies.

Top module: `flash_status_reg`

## Requirements
- R1: While reset is asserted and after its release, the status word is 80h. No data lane is enabled until a read begins.
- R2: `wsm_set` may set bits 7..3, and a set request for bits 2..0 has no effect. Bits 2..0 always read 0.
- R3: `wsm_clr` may clear bits 7 and 6. A clear request for bits 5..0 has no effect, so the fault bits 5..3 cannot be cleared by the state machine.
- R4: A one-cycle `host_clr` clears bits 5..3 and leaves bits 7 and 6 unchanged.
- R5: When a set and a clear (from `wsm_clr` or `host_clr`) hit the same bit in the same cycle, the set wins.
- R6: A read begins when the later of `ce_n` and `oe_n` falls. The snapshot is then loaded from the live word and does not change while the read continues, even if the live word changes.
- R7: A change in the live word reaches `dq_out[7:0]` only after `ce_n` or `oe_n` has gone high and low again. Either pin may be the one that toggles.
- R8: In word mode (`byte_mode`=0), all 16 lanes are enabled during a read and `dq_out[15:8]` reads 00h.
- R9: In byte mode (`byte_mode`=1), only lanes 7..0 are enabled during a read. Lanes 14..8 float, and lane 15 stays undriven because it serves as an address input.
- R10: The snapshot and the lane enables change exactly `SYNC_STAGES`+1 clock edges after the pins start a read. The lane enables drop `SYNC_STAGES`+1 edges after the pins end it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wsm_set | input | 8 | Per-bit set request from the state machine |
| wsm_clr | input | 8 | Per-bit clear request from the state machine |
| host_clr | input | 1 | Clear-status strobe from the command sequencer |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| byte_mode | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| dq_out | output | 16 | Value for the data lanes |
| dq_oe | output | 16 | Per-lane drive enable |

## Verification
A vector table applies set masks, clear masks and host clears, alone and in colliding pairs. It also includes requests aimed at the reserved and sticky bits. This separates a correct set-over-clear priority from the reverse, and a correct sticky rule from one that lets the state machine drop fault bits. Each vector is read back with the bus width alternating, which tells the word-mode and byte-mode lane enables apart. Directed reads follow. One changes the live word during a read. Others toggle only `oe_n` or only `ce_n`. One samples the lane enables on each clock edge around the start of a read. Together these catch a snapshot that follows the live word, a capture on the wrong pin edge, and an off-by-one in latency.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int STAT_W = 8;
  localparam int BUS_W  = 16;

  localparam int B_READY   = 7;
  localparam int B_SUSP    = 6;
  localparam int B_ERS_ERR = 5;
  localparam int B_PRG_ERR = 4;
  localparam int B_VPP_ERR = 3;

  localparam logic [STAT_W-1:0] STAT_RST       = 8'h80;
  localparam logic [STAT_W-1:0] WSM_SET_MASK   = 8'hF8;
  localparam logic [STAT_W-1:0] WSM_CLR_MASK   = 8'hC0;
  localparam logic [STAT_W-1:0] HOST_CLR_MASK  = 8'h38;
  localparam logic [STAT_W-1:0] RSVD_MASK      = 8'h07;
endpackage

// File: rtl/fsr_pin_sync.sv
module fsr_pin_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_sync
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= {W{RST_VAL}};
        else if (s == 0) chain[s] <= pin_in;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/fsr_live.sv
module fsr_live
  import fsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_req,
  input  logic [STAT_W-1:0] clr_req,
  input  logic              host_clr,
  output logic [STAT_W-1:0] live
);
  logic [STAT_W-1:0] cleared;
  logic [STAT_W-1:0] nxt;

  always_comb begin
    cleared = live & ~(clr_req & WSM_CLR_MASK)
                   & ~({STAT_W{host_clr}} & HOST_CLR_MASK);
    // set applied after clear: a colliding set wins
    nxt = (cleared | (set_req & WSM_SET_MASK)) & ~RSVD_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) live <= STAT_RST;
    else        live <= nxt;
  end
endmodule

// File: rtl/fsr_capture.sv
module fsr_capture
  import fsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s_n,
  input  logic              oe_s_n,
  input  logic              byte_mode,
  input  logic [STAT_W-1:0] live,
  output logic [BUS_W-1:0]  dq_out,
  output logic [BUS_W-1:0]  dq_oe
);
  localparam int UPPER_W = BUS_W - STAT_W;

  logic              rd_act;
  logic              rd_act_q;
  logic              cap;
  logic [STAT_W-1:0] snap;
  logic              lo_en;
  logic              hi_en;

  assign rd_act = ~ce_s_n & ~oe_s_n;
  assign cap    = rd_act & ~rd_act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      snap     <= STAT_RST;
      lo_en    <= 1'b0;
      hi_en    <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      if (cap) snap <= live;
      lo_en <= rd_act;
      hi_en <= rd_act & ~byte_mode;
    end
  end

  generate
    for (genvar l = 0; l < BUS_W; l++) begin : g_lane
      if (l < STAT_W) begin : g_lo
        assign dq_out[l] = snap[l];
        assign dq_oe[l]  = lo_en;
      end else begin : g_hi
        assign dq_out[l] = 1'b0;
        assign dq_oe[l]  = hi_en;
      end
    end
  endgenerate

  initial begin
    if (UPPER_W < 0) $display("fsr_capture: bus narrower than status");
  end
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import fsr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] wsm_set,
  input  logic [STAT_W-1:0] wsm_clr,
  input  logic              host_clr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              byte_mode,
  output logic [BUS_W-1:0]  dq_out,
  output logic [BUS_W-1:0]  dq_oe
);
  logic [1:0]        pins_s;
  logic [STAT_W-1:0] stat_live;

  fsr_pin_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   ({ce_n, oe_n}),
    .pin_sync (pins_s)
  );

  fsr_live u_live (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_req  (wsm_set),
    .clr_req  (wsm_clr),
    .host_clr (host_clr),
    .live     (stat_live)
  );

  fsr_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_s_n    (pins_s[1]),
    .oe_s_n    (pins_s[0]),
    .byte_mode (byte_mode),
    .live      (stat_live),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
  import fsr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [STAT_W-1:0] wsm_set,
  input logic              host_clr,
  input logic [STAT_W-1:0] stat_live,
  input logic [BUS_W-1:0]  dq_out,
  input logic [BUS_W-1:0]  dq_oe
);
  // R2: reserved bits never set
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stat_live[2:0] == 3'b000);

  // R2, R5: a requested set always lands
  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|wsm_set[7:3]) |=>
      ((stat_live[7:3] & $past(wsm_set[7:3])) == $past(wsm_set[7:3])));

  // R3: without host clear, fault bits never drop
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !host_clr |=>
      ((stat_live[5:3] & $past(stat_live[5:3])) == $past(stat_live[5:3])));

  // R4: host clear keeps bits 7 and 6
  a_r4_host_keeps_top: assert property (@(posedge clk) disable iff (!rst_n)
    host_clr |=> ((stat_live[7:6] & $past(stat_live[7:6])) == $past(stat_live[7:6])));

  // R6: snapshot stable throughout a read
  a_r6_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe[0] && $past(dq_oe[0])) |-> $stable(dq_out));

  // R8: upper byte always reads zero
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dq_out[15:8] == 8'h00);

  // R9: upper lanes move together and only with the low lanes
  a_r9_lane_group: assert property (@(posedge clk) disable iff (!rst_n)
    (|dq_oe[15:8]) |-> ((&dq_oe[15:8]) && (&dq_oe[7:0])));
endmodule

bind flash_status_reg fsr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wsm_set   (wsm_set),
  .host_clr  (host_clr),
  .stat_live (stat_live),
  .dq_out    (dq_out),
  .dq_oe     (dq_oe)
);

// File: tb/flash_status_reg_bench.sv
module flash_status_reg_bench;
  localparam int LAT = 3; // SYNC_STAGES + 1

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  wsm_set = '0;
  logic [7:0]  wsm_clr = '0;
  logic        host_clr = 1'b0;
  logic        ce_n = 1'b1;
  logic        oe_n = 1'b1;
  logic        byte_mode = 1'b0;
  logic [15:0] dq_out;
  logic [15:0] dq_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_status_reg u_flash_status_reg (
    .clk(clk), .rst_n(rst_n), .wsm_set(wsm_set), .wsm_clr(wsm_clr),
    .host_clr(host_clr), .ce_n(ce_n), .oe_n(oe_n), .byte_mode(byte_mode),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // {byte_mode, host_clr, set, clr, expected status}
  localparam logic [25:0] VEC [0:8] = '{
    {1'b0, 1'b0, 8'h08, 8'h00, 8'h88},  // R2 set fault
    {1'b1, 1'b0, 8'h40, 8'h80, 8'h48},  // R3 clear ready, set suspend
    {1'b0, 1'b0, 8'h80, 8'h40, 8'h88},  // R3 clear suspend
    {1'b1, 1'b0, 8'h07, 8'h3F, 8'h88},  // R2 R3 reserved/sticky ignored
    {1'b0, 1'b1, 8'h00, 8'h00, 8'h80},  // R4 host clear
    {1'b1, 1'b0, 8'h30, 8'h80, 8'h30},  // R2 two faults
    {1'b0, 1'b1, 8'h00, 8'h00, 8'h00},  // R4 clear leaves 7:6
    {1'b1, 1'b1, 8'h90, 8'h00, 8'h90},  // R5 set beats host clear
    {1'b0, 1'b0, 8'h40, 8'h40, 8'hD0}   // R5 set beats wsm clear
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_start();
    ce_n = 1'b0; oe_n = 1'b0;
    cyc(LAT + 1);
  endtask

  task automatic read_end();
    ce_n = 1'b1; oe_n = 1'b1;
    cyc(LAT + 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R1 lanes idle in reset", dq_oe, 16'h0000);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 lanes idle after reset", dq_oe, 16'h0000);
    read_start();
    chk("R1 reset value", dq_out, 16'h0080);
    read_end();

    for (int i = 0; i < 9; i++) begin
      byte_mode = VEC[i][25];
      host_clr  = VEC[i][24];
      wsm_set   = VEC[i][23:16];
      wsm_clr   = VEC[i][15:8];
      cyc(1);
      host_clr = 1'b0; wsm_set = '0; wsm_clr = '0;
      read_start();
      chk($sformatf("R2/R3/R4/R5 vector %0d value", i), dq_out, {8'h00, VEC[i][7:0]});
      chk(VEC[i][25] ? "R9 byte lanes" : "R8 word lanes", dq_oe,
          VEC[i][25] ? 16'h00FF : 16'hFFFF);
      read_end();
      chk("R10 lanes drop after read", dq_oe, 16'h0000);
    end
    // status now D0

    // R6: live change during a read does not reach the bus
    byte_mode = 1'b0;
    read_start();
    wsm_set = 8'h20; cyc(1); wsm_set = '0;
    cyc(2);
    chk("R6 snapshot held during read", dq_out, 16'h00D0);
    // R7: toggle only oe_n
    oe_n = 1'b1; cyc(LAT + 1);
    oe_n = 1'b0; cyc(LAT + 1);
    chk("R7 oe toggle shows new value", dq_out, 16'h00F0);
    // R7: toggle only ce_n, with ce falling last
    wsm_clr = 8'h80; cyc(1); wsm_clr = '0;
    ce_n = 1'b1; cyc(LAT + 1);
    ce_n = 1'b0; cyc(LAT + 1);
    chk("R7 ce toggle shows new value", dq_out, 16'h0070);
    read_end();

    // R10: latency of the lane enables, oe falling last
    ce_n = 1'b0; cyc(3);
    chk("R10 ce alone starts nothing", dq_oe, 16'h0000);
    oe_n = 1'b0;
    cyc(LAT - 1);
    chk("R10 lanes still off one edge early", dq_oe, 16'h0000);
    cyc(1);
    chk("R10 lanes on at latency", dq_oe, 16'hFFFF);
    chk("R10 snapshot at latency", dq_out, 16'h0070);
    ce_n = 1'b1; oe_n = 1'b1;
    cyc(LAT - 1);
    chk("R10 lanes still on one edge early", dq_oe, 16'hFFFF);
    cyc(1);
    chk("R10 lanes off at latency", dq_oe, 16'h0000);

    // R3: clearing fault bits by the state machine is ignored
    wsm_clr = 8'hFF; cyc(1); wsm_clr = '0;
    read_start();
    chk("R3 faults survive full clear mask", dq_out, 16'h0030);
    read_end();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule